// File: doc/BRIEF.md
# DMA Channel Run-State Sequencer

This block tracks the run state of a single descriptor-driven DMA channel. Software-side control writes reach it as a one-cycle write strobe carrying four bits: enable, continue, continue-from-start and pointer mode. Pointer mode selects whether descriptors sit in registers or in memory. The sequencer holds the current source and destination descriptor pointers and loads them from two start addresses when the channel starts. It advances the source pointer as descriptors finish.

A separate datapath reports each finished descriptor with a 2-bit command and a linear/linked flag. It can also report an error. A linear descriptor moves the source pointer forward by one descriptor. A linked descriptor makes the sequencer request the 64-bit next-pointer word stored just past the descriptor. The sequencer then waits for an acknowledge that returns the new pointer. The block drives a 2-bit status code, the pointers, the fetch request and its address, and one-cycle done and pause strobes for the interrupt logic.

Top module: `dma_run_seq`

## Requirements
- R1: After reset the status code is 0, both pointers are 0, the enable and continue bits read 0, and no strobe or fetch request is active.
- R2: A control write with enable=1 while the status is 0 loads the source and destination pointers from their start addresses and moves the status to 1 (enabled), with the enable bit reading 1.
- R3: Each descriptor completion seen while enabled gives one done pulse. In memory mode (pointer mode=1), a linear descriptor (linked flag=0) whose command is neither halt nor stop advances the source pointer by 16 bytes.
- R4: A plain linked descriptor (linked flag=1) in memory mode raises the fetch request, with the fetch address equal to the source pointer plus 16. The request holds, with the status still reading 1, until the acknowledge arrives. On the acknowledge the source pointer takes the returned value and the request drops.
- R5: Command 1 (halt) moves the status to 2 (paused), gives a pause pulse and leaves the enable bit set.
- R6: Command 2 (stop), or any completion while pointer mode=0, clears the enable bit and moves the status to 0.
- R7: A control write with enable=1, continue=1 and continue-from-start=1 while paused reloads both pointers from the start addresses, moves the status to 1 and clears the continue bit.
- R8: A control write with enable=1, continue=1 and continue-from-start=0 while paused advances the source pointer past the halted descriptor. A linear descriptor adds 16 bytes. A linked descriptor fetches the next pointer through the request/acknowledge handshake.
- R9: While paused, a control write with enable=0 and continue=1 moves the status to 0. A control write with continue=0 leaves the status at 2.
- R10: An error event, or (in memory mode only) a current pointer that is not a multiple of 16 while enabled, sets an error flag. The error flag forces the status code to 3 and clears the enable bit. The next control write with enable=1 clears the error and restarts the channel from the start addresses.
- R11: A descriptor completion while the status is 0 or 2 gives no done pulse and leaves the source pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_wr_i | input | 1 | Control write strobe |
| en_i | input | 1 | Enable bit of the control write |
| cont_i | input | 1 | Continue bit of the control write |
| cont_start_i | input | 1 | Continue-from-start bit of the control write |
| ptr_mem_i | input | 1 | Pointer mode of the control write: 1 memory, 0 registers |
| src_start_i | input | 49 | Source start address |
| dst_start_i | input | 49 | Destination start address |
| dsc_done_i | input | 1 | Descriptor completion event |
| dsc_cmd_i | input | 2 | Command of the completed descriptor: 1 halt, 2 stop |
| dsc_linked_i | input | 1 | Type of the completed descriptor: 1 linked, 0 linear |
| err_i | input | 1 | Error event from the datapath |
| nxt_ack_i | input | 1 | Next-pointer fetch acknowledge |
| nxt_ptr_i | input | 49 | Next pointer returned with the acknowledge |
| state_o | output | 2 | Status: 0 disabled, 1 enabled, 2 paused, 3 error |
| en_o | output | 1 | Current enable bit |
| cont_o | output | 1 | Current continue bit |
| src_ptr_o | output | 49 | Current source descriptor pointer |
| dst_ptr_o | output | 49 | Current destination descriptor pointer |
| nxt_req_o | output | 1 | Next-pointer fetch request |
| nxt_addr_o | output | 49 | Address of the next-pointer word |
| done_o | output | 1 | Descriptor done pulse |
| pause_o | output | 1 | Pause pulse |

## Verification
Status, enable, continue, pointers, request and both strobes are registered. Each is due one clock edge after the cycle in which its stimulus is sampled. The fetch address follows the source pointer with no extra delay. The alignment error is the only two-step result: the edge that accepts enable loads the misaligned pointer and shows status 1, and the following edge reports status 3. The bench drives inputs just after a falling edge, lets one rising edge pass and compares at the next falling edge. For the alignment case it compares at both steps.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_OFF   = 2'd0,
    SEQ_RUN   = 2'd1,
    SEQ_HALT  = 2'd2,
    SEQ_FETCH = 2'd3
  } seq_st_e;

  localparam logic [1:0] CMD_HALT   = 2'd1;
  localparam logic [1:0] CMD_STOP   = 2'd2;
  localparam logic [1:0] STATUS_ERR = 2'd3;
endpackage

// File: rtl/dma_seq_ptr.sv
module dma_seq_ptr #(
  parameter int PTR_W      = 49,
  parameter int DESC_BYTES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_start_i,
  input  logic [PTR_W-1:0] start_i,
  input  logic             ld_nxt_i,
  input  logic [PTR_W-1:0] nxt_i,
  input  logic             adv_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] STEP = PTR_W'(DESC_BYTES);

  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ptr_q <= '0;
    else if (ld_start_i) ptr_q <= start_i;
    else if (ld_nxt_i)   ptr_q <= nxt_i;
    else if (adv_i)      ptr_q <= ptr_q + STEP;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
#(
  parameter int ALIGN_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_wr_i,
  input  logic               en_i,
  input  logic               cont_i,
  input  logic               cont_start_i,
  input  logic               ptr_mem_i,
  input  logic               dsc_done_i,
  input  logic [1:0]         dsc_cmd_i,
  input  logic               dsc_linked_i,
  input  logic               err_i,
  input  logic               nxt_ack_i,
  input  logic [ALIGN_W-1:0] src_lo_i,
  input  logic [ALIGN_W-1:0] dst_lo_i,
  output logic [1:0]         state_o,
  output logic               en_o,
  output logic               cont_o,
  output logic               nxt_req_o,
  output logic               done_o,
  output logic               pause_o,
  output logic               ld_start_o,
  output logic               adv_src_o,
  output logic               ld_nxt_o
);
  seq_st_e st_q, st_d;
  logic err_q, err_d, en_q, en_d, cont_q, cont_d, mem_q, mem_d;
  logic lnk_q, lnk_d, done_q, done_d, pause_q, pause_d;
  logic misaligned;

  assign misaligned = (|src_lo_i) | (|dst_lo_i);

  always_comb begin
    st_d       = st_q;
    err_d      = err_q;
    en_d       = en_q;
    cont_d     = cont_q;
    mem_d      = mem_q;
    lnk_d      = lnk_q;
    done_d     = 1'b0;
    pause_d    = 1'b0;
    ld_start_o = 1'b0;
    adv_src_o  = 1'b0;
    ld_nxt_o   = 1'b0;

    if (ctrl_wr_i) begin
      en_d   = en_i;
      cont_d = cont_i;
      mem_d  = ptr_mem_i;
      if (en_i) err_d = 1'b0;
    end

    unique case (st_q)
      SEQ_OFF: begin
        if (ctrl_wr_i && en_i) begin
          ld_start_o = 1'b1;
          st_d       = SEQ_RUN;
        end
      end
      SEQ_HALT: begin
        if (ctrl_wr_i && cont_i) begin
          if (en_i) begin
            cont_d = 1'b0;
            st_d   = SEQ_RUN;
            if (cont_start_i) ld_start_o = 1'b1;
            else if (lnk_q)   st_d = SEQ_FETCH;
            else              adv_src_o = 1'b1;
          end else begin
            st_d = SEQ_OFF;
          end
        end
      end
      SEQ_RUN: begin
        if (mem_q && misaligned) begin
          err_d = 1'b1;
          en_d  = 1'b0;
          st_d  = SEQ_OFF;
        end else if (dsc_done_i) begin
          done_d = 1'b1;
          if (!mem_q || dsc_cmd_i == CMD_STOP) begin
            en_d = 1'b0;
            st_d = SEQ_OFF;
          end else if (dsc_cmd_i == CMD_HALT) begin
            st_d    = SEQ_HALT;
            pause_d = 1'b1;
            lnk_d   = dsc_linked_i;
          end else if (dsc_linked_i) begin
            st_d = SEQ_FETCH;
          end else begin
            adv_src_o = 1'b1;
          end
        end
      end
      SEQ_FETCH: begin
        if (nxt_ack_i) begin
          ld_nxt_o = 1'b1;
          st_d     = SEQ_RUN;
        end
      end
      default: st_d = SEQ_OFF;
    endcase

    // error event overrides every transition
    if (err_i) begin
      err_d      = 1'b1;
      en_d       = 1'b0;
      st_d       = SEQ_OFF;
      pause_d    = 1'b0;
      ld_start_o = 1'b0;
      adv_src_o  = 1'b0;
      ld_nxt_o   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SEQ_OFF;
      err_q   <= 1'b0;
      en_q    <= 1'b0;
      cont_q  <= 1'b0;
      mem_q   <= 1'b0;
      lnk_q   <= 1'b0;
      done_q  <= 1'b0;
      pause_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      err_q   <= err_d;
      en_q    <= en_d;
      cont_q  <= cont_d;
      mem_q   <= mem_d;
      lnk_q   <= lnk_d;
      done_q  <= done_d;
      pause_q <= pause_d;
    end
  end

  always_comb begin
    if (err_q)                  state_o = STATUS_ERR;
    else if (st_q == SEQ_FETCH) state_o = 2'(SEQ_RUN);
    else                        state_o = 2'(st_q);
  end

  assign en_o      = en_q;
  assign cont_o    = cont_q;
  assign nxt_req_o = (st_q == SEQ_FETCH);
  assign done_o    = done_q;
  assign pause_o   = pause_q;
endmodule

// File: rtl/dma_run_seq.sv
module dma_run_seq #(
  parameter int PTR_W      = 49,
  parameter int DESC_BYTES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_wr_i,
  input  logic             en_i,
  input  logic             cont_i,
  input  logic             cont_start_i,
  input  logic             ptr_mem_i,
  input  logic [PTR_W-1:0] src_start_i,
  input  logic [PTR_W-1:0] dst_start_i,
  input  logic             dsc_done_i,
  input  logic [1:0]       dsc_cmd_i,
  input  logic             dsc_linked_i,
  input  logic             err_i,
  input  logic             nxt_ack_i,
  input  logic [PTR_W-1:0] nxt_ptr_i,
  output logic [1:0]       state_o,
  output logic             en_o,
  output logic             cont_o,
  output logic [PTR_W-1:0] src_ptr_o,
  output logic [PTR_W-1:0] dst_ptr_o,
  output logic             nxt_req_o,
  output logic [PTR_W-1:0] nxt_addr_o,
  output logic             done_o,
  output logic             pause_o
);
  localparam int ALIGN_W = $clog2(DESC_BYTES);
  localparam logic [PTR_W-1:0] STEP = PTR_W'(DESC_BYTES);

  logic ld_start, adv_src, ld_nxt;

  dma_seq_fsm #(.ALIGN_W(ALIGN_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_wr_i    (ctrl_wr_i),
    .en_i         (en_i),
    .cont_i       (cont_i),
    .cont_start_i (cont_start_i),
    .ptr_mem_i    (ptr_mem_i),
    .dsc_done_i   (dsc_done_i),
    .dsc_cmd_i    (dsc_cmd_i),
    .dsc_linked_i (dsc_linked_i),
    .err_i        (err_i),
    .nxt_ack_i    (nxt_ack_i),
    .src_lo_i     (src_ptr_o[ALIGN_W-1:0]),
    .dst_lo_i     (dst_ptr_o[ALIGN_W-1:0]),
    .state_o      (state_o),
    .en_o         (en_o),
    .cont_o       (cont_o),
    .nxt_req_o    (nxt_req_o),
    .done_o       (done_o),
    .pause_o      (pause_o),
    .ld_start_o   (ld_start),
    .adv_src_o    (adv_src),
    .ld_nxt_o     (ld_nxt)
  );

  dma_seq_ptr #(.PTR_W(PTR_W), .DESC_BYTES(DESC_BYTES)) u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_start_i (ld_start),
    .start_i    (src_start_i),
    .ld_nxt_i   (ld_nxt),
    .nxt_i      (nxt_ptr_i),
    .adv_i      (adv_src),
    .ptr_o      (src_ptr_o)
  );

  // destination pointer only reloads here; its advance belongs to the datapath
  dma_seq_ptr #(.PTR_W(PTR_W), .DESC_BYTES(DESC_BYTES)) u_dst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_start_i (ld_start),
    .start_i    (dst_start_i),
    .ld_nxt_i   (1'b0),
    .nxt_i      ('0),
    .adv_i      (1'b0),
    .ptr_o      (dst_ptr_o)
  );

  // next-pointer word sits right after the current descriptor
  assign nxt_addr_o = src_ptr_o + STEP;
endmodule

// File: rtl/dma_run_seq_chk.sv
module dma_run_seq_chk #(
  parameter int PTR_W = 49
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dsc_done_i,
  input logic             err_i,
  input logic             nxt_ack_i,
  input logic [PTR_W-1:0] nxt_ptr_i,
  input logic [1:0]       state_o,
  input logic             en_o,
  input logic [PTR_W-1:0] src_ptr_o,
  input logic             nxt_req_o,
  input logic             done_o,
  input logic             pause_o
);
  // R3
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(dsc_done_i));

  // R5
  pause_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_o |-> state_o == 2'd2);

  // R4
  req_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nxt_req_o |-> state_o == 2'd1);

  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nxt_req_o && !nxt_ack_i && !err_i |=> nxt_req_o && $stable(src_ptr_o));

  // R4
  ack_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nxt_req_o && nxt_ack_i && !err_i |=> !nxt_req_o && src_ptr_o == $past(nxt_ptr_i));

  // R10
  err_no_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd3 |-> !en_o);
endmodule

bind dma_run_seq dma_run_seq_chk #(.PTR_W(PTR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dsc_done_i (dsc_done_i),
  .err_i      (err_i),
  .nxt_ack_i  (nxt_ack_i),
  .nxt_ptr_i  (nxt_ptr_i),
  .state_o    (state_o),
  .en_o       (en_o),
  .src_ptr_o  (src_ptr_o),
  .nxt_req_o  (nxt_req_o),
  .done_o     (done_o),
  .pause_o    (pause_o)
);

// File: tb/dma_run_seq_test.sv
`timescale 1ns/100ps
module dma_run_seq_test;
  localparam int PTR_W = 49;
  localparam logic [PTR_W-1:0] SS  = 49'h1_0000_0000_0100;
  localparam logic [PTR_W-1:0] DS  = 49'h0_0000_0002_0200;
  localparam logic [PTR_W-1:0] LP  = 49'h0_0000_ABCD_0040;
  localparam logic [PTR_W-1:0] LP2 = 49'h1_2345_0000_0080;

  typedef struct packed {
    logic wr, en, cont, cs, mem, dn;
    logic [1:0] cmd;
    logic lnk;
    logic [1:0] st;
    logic [3:0] off;
    logic xen, xdn, xps;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VT [NV] = '{
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,2'd0,1'b0,2'd1,4'd0,1'b1,1'b0,1'b0}, // R2 start
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,1'b0,2'd1,4'd1,1'b1,1'b1,1'b0}, // R3 linear
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,1'b0,2'd1,4'd2,1'b1,1'b1,1'b0}, // R3 linear
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd1,1'b0,2'd2,4'd2,1'b1,1'b1,1'b1}, // R5 halt
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,1'b0,2'd2,4'd2,1'b1,1'b0,1'b0}, // R11 paused
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,1'b0,2'd2,4'd2,1'b0,1'b0,1'b0}, // R9 no cont
    '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,2'd0,1'b0,2'd1,4'd3,1'b1,1'b0,1'b0}, // R8 resume
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd2,1'b0,2'd0,4'd3,1'b0,1'b1,1'b0}, // R6 stop
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,2'd1,4'd0,1'b1,1'b0,1'b0}, // R2 reg mode
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,1'b0,2'd0,4'd0,1'b0,1'b1,1'b0}  // R6 reg mode
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_wr = 0, en = 0, cont = 0, cs = 0, mem = 0;
  logic [PTR_W-1:0] src_start = SS, dst_start = DS, nxt_ptr = '0;
  logic dn = 0, lnk = 0, err = 0, ack = 0;
  logic [1:0] cmd = 2'd0;
  logic [1:0] state;
  logic en_q, cont_q, req, done, pause;
  logic [PTR_W-1:0] src_ptr, dst_ptr, nxt_addr;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_run_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_wr_i(ctrl_wr), .en_i(en), .cont_i(cont),
    .cont_start_i(cs), .ptr_mem_i(mem), .src_start_i(src_start), .dst_start_i(dst_start),
    .dsc_done_i(dn), .dsc_cmd_i(cmd), .dsc_linked_i(lnk), .err_i(err),
    .nxt_ack_i(ack), .nxt_ptr_i(nxt_ptr), .state_o(state), .en_o(en_q), .cont_o(cont_q),
    .src_ptr_o(src_ptr), .dst_ptr_o(dst_ptr), .nxt_req_o(req), .nxt_addr_o(nxt_addr),
    .done_o(done), .pause_o(pause)
  );

  task automatic chk(input string req_tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic idle();
    ctrl_wr = 0; en = 0; cont = 0; cs = 0; dn = 0; cmd = 2'd0; lnk = 0; err = 0; ack = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input logic e, input logic c, input logic s, input logic m);
    ctrl_wr = 1; en = e; cont = c; cs = s; mem = m;
    step();
  endtask

  task automatic dsc(input logic [1:0] c, input logic l);
    dn = 1; cmd = c; lnk = l;
    step();
  endtask

  initial begin
    #(100000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 state", 64'(state), 64'd0);
    chk("R1 src", 64'(src_ptr), 64'd0);
    chk("R1 dst", 64'(dst_ptr), 64'd0);
    chk("R1 flags", 64'({en_q, cont_q, req, done, pause}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      ctrl_wr = VT[i].wr; en = VT[i].en; cont = VT[i].cont; cs = VT[i].cs;
      if (VT[i].wr) mem = VT[i].mem;
      dn = VT[i].dn; cmd = VT[i].cmd; lnk = VT[i].lnk;
      step();
      chk($sformatf("R2-vector%0d state", i), 64'(state), 64'(VT[i].st));
      chk($sformatf("R3 vector%0d src", i), 64'(src_ptr), 64'(SS + 49'(VT[i].off) * 49'd16));
      chk($sformatf("R6 vector%0d en", i), 64'(en_q), 64'(VT[i].xen));
      chk($sformatf("R3 vector%0d done", i), 64'(done), 64'(VT[i].xdn));
      chk($sformatf("R5 vector%0d pause", i), 64'(pause), 64'(VT[i].xps));
    end
    chk("R2 dst", 64'(dst_ptr), 64'(DS));

    // R4 linked advance
    wr(1, 0, 0, 1);
    chk("R2 state", 64'(state), 64'd1);
    dsc(2'd0, 1);
    chk("R4 req", 64'(req), 64'd1);
    chk("R4 addr", 64'(nxt_addr), 64'(SS + 49'd16));
    chk("R4 state", 64'(state), 64'd1);
    chk("R3 done", 64'(done), 64'd1);
    step();
    chk("R4 hold req", 64'(req), 64'd1);
    chk("R4 hold src", 64'(src_ptr), 64'(SS));
    ack = 1; nxt_ptr = LP;
    step();
    chk("R4 src loaded", 64'(src_ptr), 64'(LP));
    chk("R4 req drop", 64'(req), 64'd0);

    // R8 resume after halted linked descriptor
    dsc(2'd1, 1);
    chk("R5 state", 64'(state), 64'd2);
    wr(1, 1, 0, 1);
    chk("R8 req", 64'(req), 64'd1);
    chk("R8 addr", 64'(nxt_addr), 64'(LP + 49'd16));
    ack = 1; nxt_ptr = LP2;
    step();
    chk("R8 src", 64'(src_ptr), 64'(LP2));
    chk("R8 state", 64'(state), 64'd1);

    // R7 resume from start
    dsc(2'd1, 0);
    wr(1, 1, 1, 1);
    chk("R7 src", 64'(src_ptr), 64'(SS));
    chk("R7 dst", 64'(dst_ptr), 64'(DS));
    chk("R7 state", 64'(state), 64'd1);
    chk("R7 cont", 64'(cont_q), 64'd0);

    // R9 disable from paused with continue
    dsc(2'd1, 0);
    wr(0, 1, 0, 1);
    chk("R9 state", 64'(state), 64'd0);
    chk("R9 en", 64'(en_q), 64'd0);

    // R10 error event and clearing
    wr(1, 0, 0, 1);
    err = 1;
    step();
    chk("R10 err state", 64'(state), 64'd3);
    chk("R10 err en", 64'(en_q), 64'd0);
    wr(1, 0, 0, 1);
    chk("R10 clear state", 64'(state), 64'd1);
    chk("R10 clear src", 64'(src_ptr), 64'(SS));

    // R10 misaligned pointer in memory mode
    dsc(2'd2, 0);
    src_start = SS + 49'd4;
    wr(1, 0, 0, 1);
    chk("R10 mis load", 64'(state), 64'd1);
    step();
    chk("R10 mis state", 64'(state), 64'd3);
    chk("R10 mis en", 64'(en_q), 64'd0);
    wr(1, 0, 0, 0);
    step();
    chk("R10 reg mode no err", 64'(state), 64'd1);

    // R11 completion while disabled
    dsc(2'd0, 0);
    chk("R6 reg done state", 64'(state), 64'd0);
    dsc(2'd0, 0);
    chk("R11 no done", 64'(done), 64'd0);
    chk("R11 src kept", 64'(src_ptr), 64'(SS + 49'd4));
    chk("R11 state", 64'(state), 64'd0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule